// File: doc/BRIEF.md
# Status word access unit

This unit keeps a processor's 32-bit status word as four separately stored groups: the condition flags (four bits), the sticky saturation flag, the four lane-select flags, and a base group that holds every other bit. A read request joins the groups back into one word. The read result is then masked, so that only the architecturally visible bits come out. The result is registered and appears one cycle after the request.

A write request takes its source from either a register operand or an immediate operand. A four-bit lane enable chooses, byte by byte, which parts of the current word are replaced. The new word is then split back into the groups. A system control bit can stop a write from setting the fast-interrupt mask bit when that bit is currently clear.

Reads and writes only take effect when the condition-pass input is high. Other datapath units can set the saturation flag, or load the lane-select flags, through two side ports. In any cycle where an explicit write takes effect, the side ports are ignored.

Top module: `status_word_unit`

## Requirements
- R1: During and after reset, `rd_data` is 0. The stored word equals the reset word 0x000001D3. A first read therefore returns 0x000001D3.
- R2: A read that takes effect returns the stored word ANDed with 0xF8FF03DF. Bits outside that mask always read as 0.
- R3: A write that takes effect replaces byte k (bits 8k+7:8k) of the stored word only when `wr_lane_en[k]` is 1. Disabled bytes keep their value, including the flag bits they contain.
- R4: The condition flags sit at bits 31:28, the saturation flag at bit 27, and the lane-select flags at bits 19:16. A write through byte 3 or byte 2 overwrites these flags exactly as it overwrites any other bit, and a later read returns them.
- R5: `wr_use_imm` = 1 selects `wr_imm_data` as the write source. `wr_use_imm` = 0 selects `wr_reg_data`. The source that is not selected has no effect.
- R6: When `cond_ok` is 0, read and write requests are ignored. `rd_data` keeps its value, and the stored word does not change except through the side ports.
- R7: When `fiq_lock` is 1 and bit 6 of the stored word is 0, a write leaves bit 6 at 0. When bit 6 is 1, or when `fiq_lock` is 0, bit 6 follows the enabled byte.
- R8: A write takes one cycle. A read issued in the next cycle returns the new value. A read and a write in the same cycle return the value from before the write.
- R9: `q_set_req` sets the saturation flag, which reads back at bit 27. No side-port activity clears it.
- R10: `ge_load_req` loads all four lane-select flags from `ge_load_val` in one cycle, with bit 0 of `ge_load_val` going to word bit 16.
- R11: In a cycle where a write takes effect, both side ports are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_ok | input | 1 | Condition pass; qualifies reads and writes |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| wr_use_imm | input | 1 | Write source select: 1 = immediate, 0 = register |
| wr_reg_data | input | 32 | Register write operand |
| wr_imm_data | input | 32 | Immediate write operand |
| wr_lane_en | input | 4 | Per-byte write enables |
| fiq_lock | input | 1 | Blocks setting bit 6 when it is clear |
| q_set_req | input | 1 | Side port: set the saturation flag |
| ge_load_req | input | 1 | Side port: load the lane-select flags |
| ge_load_val | input | 4 | Value for the lane-select flags |
| rd_data | output | 32 | Registered, masked read result |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, the 0xF8FF03DF visibility mask, and a reset word with bit 6 set. Because bit 6 starts set, the bench can reach both cases of the lock rule: a locked write that clears bit 6, and, after bit 6 has been cleared, a locked write that tries to set it again. With the flag positions at their defaults, side-port updates and byte-3 and byte-2 writes can collide in the same cycle, and the bench drives those collisions. It also drives a long mixed run of gated and ungated requests.

// File: rtl/swu_pkg.sv
package swu_pkg;
    localparam int LANE_W = 8;

    // Qualified request kind: {write, read}
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } op_e;
endpackage

// File: rtl/swu_lane_merge.sv
module swu_lane_merge #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / swu_pkg::LANE_W
) (
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] src_word,
    input  logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] merged
);
    localparam int LW = swu_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LW +: LW] = lane_en[g] ? src_word[g*LW +: LW]
                                               : cur_word[g*LW +: LW];
    end
endmodule

// File: rtl/swu_fiq_guard.sv
module swu_fiq_guard #(
    parameter int WORD_W  = 32,
    parameter int FIQ_BIT = 6
) (
    input  logic              lock,
    input  logic              cur_fiq,
    input  logic [WORD_W-1:0] cand_word,
    output logic [WORD_W-1:0] safe_word
);
    always_comb begin
        safe_word = cand_word;
        if (lock && !cur_fiq) begin
            safe_word[FIQ_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/swu_group_regs.sv
module swu_group_regs #(
    parameter int                 WORD_W   = 32,
    parameter logic [WORD_W-1:0]  RST_WORD = 32'h0000_01D3,
    parameter int                 COND_LSB = 28,
    parameter int                 SAT_BIT  = 27,
    parameter int                 GE_LSB   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  logic [WORD_W-1:0] new_word,
    input  logic              q_set,
    input  logic              ge_load,
    input  logic [3:0]        ge_val,
    output logic [WORD_W-1:0] base_q,
    output logic [3:0]        cond_q,
    output logic              sat_q,
    output logic [3:0]        ge_q
);
    localparam logic [WORD_W-1:0] COND_MASK = WORD_W'(4'hF) << COND_LSB;
    localparam logic [WORD_W-1:0] SAT_MASK  = WORD_W'(1)    << SAT_BIT;
    localparam logic [WORD_W-1:0] GE_MASK   = WORD_W'(4'hF) << GE_LSB;
    localparam logic [WORD_W-1:0] FLAG_MASK = COND_MASK | SAT_MASK | GE_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= RST_WORD & ~FLAG_MASK;
            cond_q <= RST_WORD[COND_LSB +: 4];
            sat_q  <= RST_WORD[SAT_BIT];
            ge_q   <= RST_WORD[GE_LSB +: 4];
        end else if (wr_take) begin
            // explicit write owns every group this cycle
            base_q <= new_word & ~FLAG_MASK;
            cond_q <= new_word[COND_LSB +: 4];
            sat_q  <= new_word[SAT_BIT];
            ge_q   <= new_word[GE_LSB +: 4];
        end else begin
            if (q_set) begin
                sat_q <= 1'b1;
            end
            if (ge_load) begin
                ge_q <= ge_val;
            end
        end
    end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit #(
    parameter int                WORD_W   = 32,
    parameter logic [WORD_W-1:0] RST_WORD = 32'h0000_01D3,
    parameter logic [WORD_W-1:0] VIS_MASK = 32'hF8FF_03DF,
    parameter int                COND_LSB = 28,
    parameter int                SAT_BIT  = 27,
    parameter int                GE_LSB   = 16,
    parameter int                FIQ_BIT  = 6,
    localparam int               LANES    = WORD_W / swu_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_ok,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wr_use_imm,
    input  logic [WORD_W-1:0] wr_reg_data,
    input  logic [WORD_W-1:0] wr_imm_data,
    input  logic [LANES-1:0]  wr_lane_en,
    input  logic              fiq_lock,
    input  logic              q_set_req,
    input  logic              ge_load_req,
    input  logic [3:0]        ge_load_val,
    output logic [WORD_W-1:0] rd_data
);
    import swu_pkg::*;

    op_e              op;
    logic             rd_take;
    logic             wr_take;
    logic [WORD_W-1:0] base_q;
    logic [3:0]       cond_q;
    logic             sat_q;
    logic [3:0]       ge_q;
    logic [WORD_W-1:0] full_word;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] new_word;

    // Request qualification
    always_comb begin
        op = op_e'({cond_ok & wr_req, cond_ok & rd_req});
    end

    always_comb begin
        unique case (op)
            OP_IDLE:  begin rd_take = 1'b0; wr_take = 1'b0; end
            OP_READ:  begin rd_take = 1'b1; wr_take = 1'b0; end
            OP_WRITE: begin rd_take = 1'b0; wr_take = 1'b1; end
            OP_BOTH:  begin rd_take = 1'b1; wr_take = 1'b1; end
        endcase
    end

    // Rejoin the groups into one word
    always_comb begin
        full_word = base_q
                  | (WORD_W'(cond_q) << COND_LSB)
                  | (WORD_W'(sat_q)  << SAT_BIT)
                  | (WORD_W'(ge_q)   << GE_LSB);
        src_word  = wr_use_imm ? wr_imm_data : wr_reg_data;
    end

    swu_lane_merge #(.WORD_W(WORD_W)) lane_i (
        .cur_word (full_word),
        .src_word (src_word),
        .lane_en  (wr_lane_en),
        .merged   (lane_word)
    );

    swu_fiq_guard #(.WORD_W(WORD_W), .FIQ_BIT(FIQ_BIT)) guard_i (
        .lock      (fiq_lock),
        .cur_fiq   (full_word[FIQ_BIT]),
        .cand_word (lane_word),
        .safe_word (new_word)
    );

    swu_group_regs #(
        .WORD_W   (WORD_W),
        .RST_WORD (RST_WORD),
        .COND_LSB (COND_LSB),
        .SAT_BIT  (SAT_BIT),
        .GE_LSB   (GE_LSB)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_take  (wr_take),
        .new_word (new_word),
        .q_set    (q_set_req),
        .ge_load  (ge_load_req),
        .ge_val   (ge_load_val),
        .base_q   (base_q),
        .cond_q   (cond_q),
        .sat_q    (sat_q),
        .ge_q     (ge_q)
    );

    // Registered read result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_take) begin
            rd_data <= full_word & VIS_MASK;
        end
    end
endmodule

// File: rtl/status_word_unit_chk.sv
module status_word_unit_chk #(
    parameter int                WORD_W   = 32,
    parameter logic [WORD_W-1:0] VIS_MASK = 32'hF8FF_03DF,
    parameter int                FIQ_BIT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cond_ok,
    input logic              rd_req,
    input logic              wr_req,
    input logic              fiq_lock,
    input logic              q_set_req,
    input logic              ge_load_req,
    input logic [3:0]        ge_load_val,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] base_q,
    input logic [3:0]        cond_q,
    input logic              sat_q,
    input logic [3:0]        ge_q
);
    a_r2_hidden_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~VIS_MASK) == '0);

    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_ok && rd_req) |=> $stable(rd_data));

    a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cond_ok && wr_req) && !q_set_req && !ge_load_req)
        |=> ($stable(base_q) && $stable(cond_q) && $stable(sat_q) && $stable(ge_q)));

    a_r7_fiq_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_ok && wr_req && fiq_lock && !base_q[FIQ_BIT]) |=> !base_q[FIQ_BIT]);

    a_r9_q_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cond_ok && wr_req) && q_set_req) |=> sat_q);

    a_r9_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cond_ok && wr_req) && sat_q) |=> sat_q);

    a_r10_ge_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cond_ok && wr_req) && ge_load_req) |=> (ge_q == $past(ge_load_val)));
endmodule

bind status_word_unit status_word_unit_chk #(
    .WORD_W   (WORD_W),
    .VIS_MASK (VIS_MASK),
    .FIQ_BIT  (FIQ_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_ok     (cond_ok),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .fiq_lock    (fiq_lock),
    .q_set_req   (q_set_req),
    .ge_load_req (ge_load_req),
    .ge_load_val (ge_load_val),
    .rd_data     (rd_data),
    .base_q      (base_q),
    .cond_q      (cond_q),
    .sat_q       (sat_q),
    .ge_q        (ge_q)
);

// File: tb/status_word_unit_tb_top.sv
module status_word_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cond_ok = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        wr_use_imm = 1'b0;
    logic [31:0] wr_reg_data = '0;
    logic [31:0] wr_imm_data = '0;
    logic [3:0]  wr_lane_en = '0;
    logic        fiq_lock = 1'b0;
    logic        q_set_req = 1'b0;
    logic        ge_load_req = 1'b0;
    logic [3:0]  ge_load_val = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural model: one plain word and the last read result
    logic [31:0] m_word;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_word_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_ok     (cond_ok),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .wr_use_imm  (wr_use_imm),
        .wr_reg_data (wr_reg_data),
        .wr_imm_data (wr_imm_data),
        .wr_lane_en  (wr_lane_en),
        .fiq_lock    (fiq_lock),
        .q_set_req   (q_set_req),
        .ge_load_req (ge_load_req),
        .ge_load_val (ge_load_val),
        .rd_data     (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, model step, and comparison on the next falling edge
    task automatic step(input string tag, input bit cp, input bit rd, input bit wr,
                        input bit imm, input logic [31:0] rv, input logic [31:0] iv,
                        input logic [3:0] be, input bit lk, input bit qs,
                        input bit gl, input logic [3:0] gv);
        logic [31:0] nw;
        logic [31:0] nrd;
        logic [31:0] src;
        cond_ok = cp; rd_req = rd; wr_req = wr; wr_use_imm = imm;
        wr_reg_data = rv; wr_imm_data = iv; wr_lane_en = be; fiq_lock = lk;
        q_set_req = qs; ge_load_req = gl; ge_load_val = gv;
        nw = m_word;
        nrd = m_rd;
        if (cp && rd) nrd = m_word & 32'hF8FF_03DF;
        if (cp && wr) begin
            src = imm ? iv : rv;
            for (int b = 0; b < 4; b++) begin
                if (be[b]) nw[8*b +: 8] = src[8*b +: 8];
            end
            if (lk && !m_word[6]) nw[6] = 1'b0;
        end else begin
            if (qs) nw[27] = 1'b1;
            if (gl) nw[19:16] = gv;
        end
        @(posedge clk);
        @(negedge clk);
        m_word = nw;
        m_rd = nrd;
        check(tag, rd_data, m_rd);
    endtask

    task automatic rd_op(input string tag);
        step(tag, 1, 1, 0, 0, '0, '0, 4'h0, 0, 0, 0, 4'h0);
    endtask

    task automatic wr_op(input string tag, input bit imm, input logic [31:0] rv,
                         input logic [31:0] iv, input logic [3:0] be, input bit lk);
        step(tag, 1, 0, 1, imm, rv, iv, be, lk, 0, 0, 4'h0);
    endtask

    initial begin
        m_word = 32'h0000_01D3;
        m_rd = '0;
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_op("R1 first read");
        check("R1 reset word", rd_data, 32'h0000_01D3);

        // R2: write every bit, hidden bits must read as zero
        wr_op("R2 write all ones", 0, 32'hFFFF_FFFF, 32'h0, 4'hF, 0);
        rd_op("R2 masked read");
        check("R2 visible mask", rd_data, 32'hF8FF_03DF);

        // R3: only byte 1 changes
        wr_op("R3 lane1 clear", 0, 32'h0000_0000, 32'hFFFF_FFFF, 4'b0010, 0);
        rd_op("R3 lane read");
        check("R3 lane1 only", rd_data, 32'hF8FF_00DF);

        // R5: immediate source selected, register ignored
        wr_op("R5 imm source", 1, 32'hFFFF_FFFF, 32'h1234_5600, 4'b0001, 0);
        rd_op("R5 imm read");
        check("R5 imm byte0", rd_data, 32'hF8FF_0000);
        wr_op("R5 reg source", 0, 32'h0000_0013, 32'h0000_00FF, 4'b0001, 0);
        rd_op("R5 reg read");

        // R4: flag groups via byte 3 and byte 2
        wr_op("R4 clear byte3", 0, 32'h0000_0000, 32'h0, 4'b1000, 0);
        rd_op("R4 flags cleared");
        wr_op("R4 set cond+q", 0, 32'hA800_0000, 32'h0, 4'b1000, 0);
        wr_op("R4 ge via byte2", 1, 32'h0, 32'h0005_0000, 4'b0100, 0);
        rd_op("R4 flags read");
        check("R4 flag values", rd_data, 32'hA805_0013);

        // R9: sticky set through side port
        wr_op("R9 clear q", 0, 32'h0, 32'h0, 4'b1000, 0);
        step("R9 q set", 0, 0, 0, 0, '0, '0, 4'h0, 0, 1, 0, 4'h0);
        step("R9 q idle", 0, 0, 0, 0, '0, '0, 4'h0, 0, 0, 0, 4'h0);
        step("R9 q set again", 0, 0, 0, 0, '0, '0, 4'h0, 0, 1, 0, 4'h0);
        rd_op("R9 q read");
        check("R9 q bit", rd_data & 32'h0800_0000, 32'h0800_0000);

        // R10: load all lane-select flags
        step("R10 ge load", 0, 0, 0, 0, '0, '0, 4'h0, 0, 0, 1, 4'b1010);
        rd_op("R10 ge read");
        check("R10 ge bits", rd_data & 32'h000F_0000, 32'h000A_0000);

        // R11: write wins over both side ports
        step("R11 collide", 1, 0, 1, 0, 32'h0000_0000, '0, 4'b1100, 0, 1, 1, 4'b1111);
        rd_op("R11 read");
        check("R11 write priority", rd_data & 32'hFFFF_0000, 32'h0000_0000);

        // R6: failed condition blocks read and write
        wr_op("R6 seed", 0, 32'h0000_00DF, 32'h0, 4'b0001, 0);
        rd_op("R6 seed read");
        step("R6 gated rw", 0, 1, 1, 0, 32'h0000_0000, '0, 4'hF, 0, 0, 0, 4'h0);
        check("R6 rd_data held", rd_data, 32'h0000_00DF);
        rd_op("R6 state kept");
        check("R6 word kept", rd_data, 32'h0000_00DF);

        // R7: lock rule on bit 6
        wr_op("R7 clear F locked (bit set)", 0, 32'h0000_0000, 32'h0, 4'b0001, 1);
        rd_op("R7 cleared");
        check("R7 clear allowed", rd_data & 32'h40, 32'h0);
        wr_op("R7 set F locked", 0, 32'h0000_00FF, 32'h0, 4'b0001, 1);
        rd_op("R7 locked read");
        check("R7 set blocked", rd_data & 32'h40, 32'h0);
        wr_op("R7 set F unlocked", 0, 32'h0000_00FF, 32'h0, 4'b0001, 0);
        rd_op("R7 unlocked read");
        check("R7 set allowed", rd_data & 32'h40, 32'h40);

        // R8: back-to-back and same-cycle ordering
        wr_op("R8 write", 0, 32'h0000_0300, 32'h0, 4'b0010, 0);
        rd_op("R8 next read");
        check("R8 new value", rd_data & 32'h0000_0300, 32'h0000_0300);
        step("R8 rd+wr same cycle", 1, 1, 1, 0, 32'h0000_0000, '0, 4'b0010, 0, 0, 0, 4'h0);
        check("R8 old value", rd_data & 32'h0000_0300, 32'h0000_0300);
        rd_op("R8 after rd+wr");
        check("R8 write landed", rd_data & 32'h0000_0300, 32'h0);

        // Mixed run: R3 R5 R6 R7 R9 R10 R11 against the model
        for (int i = 0; i < 400; i++) begin
            step("R3/R5/R6/R7/R9/R10/R11 mix", ($urandom % 4) != 0, $urandom % 2,
                 ($urandom % 3) == 0, $urandom % 2, $urandom, $urandom,
                 4'($urandom), $urandom % 2, ($urandom % 4) == 0,
                 ($urandom % 4) == 0, 4'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule